// File: doc/BRIEF.md
# Dual Phase Detector with Lock Indicator

This block serves two phase-locked loops that share one oscillator clock. Each loop has its own detector. The detector watches the rising edges of a reference pulse train and a divided feedback pulse train, both sampled on the oscillator clock. It turns the gap between paired edges into a three-state charge-pump command: drive high, drive low, or float. The command is carried as a drive-enable bit and a level bit. A per-loop polarity input swaps which direction the output drives, so that either sign of oscillator tuning can be used.

Each detector also measures the width of each error pulse in oscillator cycles and keeps a lock flag with hysteresis. The flag falls as soon as an open error pulse grows too wide. It rises again only after several tight comparisons in a row. The two flags are merged into one status pin, and a loop in power-save counts as locked for that merge. The same pin can instead show a test monitor that routes out either pulse train of either loop. A power-save input per loop floats that loop's output at once and clears its detector. After reset or power-save, the detector waits for a fresh reference edge before it accepts feedback edges, which keeps the first error pulse small.

Top module: `dual_pd_lock`

## Requirements
- R1: With polarity 1, a reference edge followed E cycles later by a feedback edge drives cp_en_o high for exactly E cycles, with cp_up_o = 1. When the feedback edge comes first, cp_up_o = 0 during the pulse.
- R2: With polarity 0, the drive level is inverted: cp_up_o = 0 when the reference leads and 1 when the feedback leads. The pulse width is unchanged.
- R3: Reference and feedback edges sampled on the same clock edge leave cp_en_o low, which is the floating state.
- R4: The lock flag clears on the clock edge at which an open error pulse has lasted 3 cycles. It does not wait for the closing edge.
- R5: The lock flag sets once 3 consecutive edge pairs have each closed with an error of at most 2 cycles. A pair with a larger error restarts the count. The flag is 0 after reset.
- R6: With mon_sel_i = 0, stat_o is 1 only if each loop is either locked or has pwr_save_i set.
- R7: With mon_sel_i = 1, stat_o shows a raw pulse input. test_sel_i[0] picks the loop (0 = first, 1 = second) and test_sel_i[1] picks the train (0 = reference, 1 = feedback). The codes {test_sel_i[1],test_sel_i[0]} = 00, 01, 10, 11 therefore select the first loop's reference, the second loop's reference, the first loop's feedback and the second loop's feedback.
- R8: While pwr_save_i of a loop is 1, that loop's cp_en_o is 0 in the same cycle, and its pulse state and lock flag are cleared.
- R9: After reset or after leaving power-save, feedback edges are ignored until the first reference edge has been seen.
- R10: After reset, cp_en_o and cp_up_o are 0, and stat_o is 0 when mon_sel_i = 0 and neither loop is in power-save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fr_i | input | 2 | Reference pulse train per loop |
| fp_i | input | 2 | Divided feedback pulse train per loop |
| pwr_save_i | input | 2 | Power-save request per loop |
| pol_i | input | 2 | Output polarity per loop |
| mon_sel_i | input | 1 | 1 selects the test monitor on stat_o |
| test_sel_i | input | 2 | Monitor route: bit 0 picks the loop, bit 1 picks feedback |
| cp_en_o | output | 2 | Charge-pump drive enable per loop (0 = floating) |
| cp_up_o | output | 2 | Charge-pump drive level per loop |
| stat_o | output | 1 | Merged lock flag or monitor signal |

## Verification
The hardest behaviour to reach from the ports is the timing of the unlock. The lock flag must already be set, and an error pulse must then stay open past the unlock threshold. The flag has to fall in the cycle the threshold is reached, while the charge-pump pulse is still running. The stimulus first qualifies a lock with several tight pairs while the other loop is held in power-save. It then opens a wide pulse and samples stat_o one cycle before and one cycle at the threshold edge. Directed sequences also interleave a wide pair into a qualification run, and enter power-save in the middle of a pulse. Seeded random pairs of both signs and polarities follow, and a bench model of the lock counter tracks them.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int NPLL  = 2;
  localparam int CNT_W = 6;

  // per-loop measurement handed from the edge pairer to the lock qualifier
  typedef struct packed {
    logic             done;  // an edge pair closes in this cycle
    logic [CNT_W-1:0] run;   // cycles the current error pulse has lasted
  } pd_meas_t;
endpackage

// File: rtl/pd_core.sv
module pd_core
  import pd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fr,
  input  logic     fp,
  input  logic     ps,
  output logic     up,
  output logic     dn,
  output pd_meas_t meas
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             fr_q, fp_q, up_q, dn_q, arm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             up_d, dn_d, arm_d;
  logic [CNT_W-1:0] cnt_d, run;
  logic             fr_rise, fp_rise, fp_eff, up_set, dn_set, act;

  always_comb begin
    fr_rise = fr & ~fr_q;
    fp_rise = fp & ~fp_q;
    fp_eff  = fp_rise & (arm_q | fr_rise);
    up_set  = up_q | fr_rise;
    dn_set  = dn_q | fp_eff;
    act     = up_q | dn_q;
    if (!act)                 run = '0;
    else if (cnt_q == CNT_MAX) run = CNT_MAX;
    else                       run = cnt_q + 1'b1;
    if (ps) begin
      up_d  = 1'b0;
      dn_d  = 1'b0;
      arm_d = 1'b0;
      cnt_d = '0;
    end else begin
      up_d  = up_set & ~dn_set;
      dn_d  = dn_set & ~up_set;
      arm_d = arm_q | fr_rise;
      cnt_d = ((up_d | dn_d) && act) ? run : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q  <= 1'b0;
      fp_q  <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      arm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fr_q  <= fr;
      fp_q  <= fp;
      up_q  <= up_d;
      dn_q  <= dn_d;
      arm_q <= arm_d;
      cnt_q <= cnt_d;
    end
  end

  assign up        = up_q;
  assign dn        = dn_q;
  assign meas.done = up_set & dn_set & ~ps;
  assign meas.run  = run;

  // R1
  excl_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_q, dn_q}));
  // R8
  ps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ps |=> !(up_q || dn_q));
  // R9
  unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_q && !dn_q && !fr_rise) |=> !dn_q);
endmodule

// File: rtl/pd_lockqual.sv
module pd_lockqual
  import pd_pkg::*;
#(
  parameter int LOCK_TH = 2,
  parameter int UNLK_TH = 3,
  parameter int QUAL    = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ps,
  input  pd_meas_t meas,
  output logic     lock
);
  localparam int GW = $clog2(QUAL + 1);
  localparam logic [CNT_W-1:0] LOCK_V = CNT_W'(LOCK_TH);
  localparam logic [CNT_W-1:0] UNLK_V = CNT_W'(UNLK_TH);
  localparam logic [GW-1:0]    QUAL_V = GW'(QUAL);

  logic          lock_q, lock_d, unlock_hit;
  logic [GW-1:0] good_q, good_d;

  always_comb begin
    unlock_hit = (meas.run >= UNLK_V);
    lock_d     = lock_q;
    good_d     = good_q;
    if (ps || unlock_hit) begin
      lock_d = 1'b0;
      good_d = '0;
    end else if (meas.done) begin
      if (meas.run <= LOCK_V) begin
        good_d = (good_q >= QUAL_V) ? good_q : good_q + 1'b1;
        if (good_d >= QUAL_V) lock_d = 1'b1;
      end else begin
        good_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else begin
      lock_q <= lock_d;
      good_q <= good_d;
    end
  end

  assign lock = lock_q;

  // R4
  unlock_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas.run >= UNLK_V) |=> !lock_q);
  // R5
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(meas.done));
endmodule

// File: rtl/pd_status.sv
module pd_status
  import pd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPLL-1:0] lock,
  input  logic [NPLL-1:0] ps,
  input  logic [NPLL-1:0] fr,
  input  logic [NPLL-1:0] fp,
  input  logic            mon_sel,
  input  logic [1:0]      test_sel,
  output logic            stat
);
  logic lock_all, mon;

  always_comb begin
    lock_all = &(lock | ps);
    mon      = test_sel[1] ? fp[test_sel[0]] : fr[test_sel[0]];
    stat     = mon_sel ? mon : lock_all;
  end

  // R6
  merge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_sel && ((~lock & ~ps) != '0)) |-> !stat);
endmodule

// File: rtl/dual_pd_lock.sv
module dual_pd_lock
  import pd_pkg::*;
#(
  parameter int LOCK_TH = 2,
  parameter int UNLK_TH = 3,
  parameter int QUAL    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPLL-1:0] fr_i,
  input  logic [NPLL-1:0] fp_i,
  input  logic [NPLL-1:0] pwr_save_i,
  input  logic [NPLL-1:0] pol_i,
  input  logic            mon_sel_i,
  input  logic [1:0]      test_sel_i,
  output logic [NPLL-1:0] cp_en_o,
  output logic [NPLL-1:0] cp_up_o,
  output logic            stat_o
);
  logic [NPLL-1:0] up, dn, lock;

  for (genvar g = 0; g < NPLL; g++) begin : g_loop
    pd_meas_t meas;

    pd_core u_core (
      .clk (clk), .rst_n (rst_n),
      .fr (fr_i[g]), .fp (fp_i[g]), .ps (pwr_save_i[g]),
      .up (up[g]), .dn (dn[g]), .meas (meas)
    );

    pd_lockqual #(.LOCK_TH(LOCK_TH), .UNLK_TH(UNLK_TH), .QUAL(QUAL)) u_qual (
      .clk (clk), .rst_n (rst_n), .ps (pwr_save_i[g]),
      .meas (meas), .lock (lock[g])
    );

    always_comb begin
      cp_en_o[g] = (up[g] | dn[g]) & ~pwr_save_i[g];
      cp_up_o[g] = cp_en_o[g] & (pol_i[g] ? up[g] : dn[g]);
    end

    // R8
    ps_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save_i[g] |-> !cp_en_o[g]);
  end

  pd_status u_status (
    .clk (clk), .rst_n (rst_n),
    .lock (lock), .ps (pwr_save_i), .fr (fr_i), .fp (fp_i),
    .mon_sel (mon_sel_i), .test_sel (test_sel_i), .stat (stat_o)
  );
endmodule

// File: tb/dual_pd_lock_bench.sv
module dual_pd_lock_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, mon;
  logic [1:0] fr, fp, ps, pol, tsel;
  logic [1:0] cp_en, cp_up;
  logic       stat;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit lock_m[2];
  int good_m[2];
  bit armed_m[2];

  dual_pd_lock u_dual_pd_lock (
    .clk (clk), .rst_n (rst_n), .fr_i (fr), .fp_i (fp), .pwr_save_i (ps),
    .pol_i (pol), .mon_sel_i (mon), .test_sel_i (tsel),
    .cp_en_o (cp_en), .cp_up_o (cp_up), .stat_o (stat)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        finish_run();
      end
    end
  end

  function automatic bit exp_stat();
    return (lock_m[0] | ps[0]) & (lock_m[1] | ps[1]);
  endfunction

  function automatic string dir_req(input int d, input bit p);
    if (d == 0) return "R3";
    return p ? "R1" : "R2";
  endfunction

  task automatic clear_model(input int c);
    lock_m[c] = 1'b0; good_m[c] = 0; armed_m[c] = 1'b0;
  endtask

  // one edge pair on loop c; d > 0 reference leads by d cycles, d < 0 feedback leads
  task automatic run_pair(input int c, input int d);
    int ad = (d < 0) ? -d : d;
    int en_cnt = 0, lvl_bad = 0;
    bit prev = exp_stat();
    bit exp_lvl = (d > 0) ? pol[c] : ~pol[c];
    for (int j = 0; j <= ad + 2; j++) begin
      @(negedge clk);
      if (j >= 1) begin
        if (cp_en[c]) begin
          en_cnt++;
          if (cp_up[c] !== exp_lvl) lvl_bad++;
        end
        if (ad >= 3 && j == 3) chk(stat === prev, "R4 hold before threshold", stat, prev);
        if (ad >= 3 && j == 4) chk(stat === 1'b0, "R4 drop at threshold", stat, 0);
      end
      fr[c] = (d >= 0) ? (j == 0) : (j == ad);
      fp[c] = (d >= 0) ? (j == ad) : (j == 0);
    end
    armed_m[c] = 1'b1;
    if (ad >= 3) begin
      lock_m[c] = 1'b0; good_m[c] = 0;
    end else begin
      good_m[c] = (good_m[c] >= 3) ? 3 : good_m[c] + 1;
      if (good_m[c] >= 3) lock_m[c] = 1'b1;
    end
    chk(en_cnt == ad, dir_req(d, pol[c]), en_cnt, ad);
    chk(lvl_bad == 0, dir_req(d, pol[c]), lvl_bad, 0);
    chk(stat === exp_stat(), "R5/R6 lock status", stat, exp_stat());
  endtask

  // feedback edge alone while unarmed: must be ignored
  task automatic fp_only(input int c);
    int en_cnt = 0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (cp_en[c]) en_cnt++;
      fp[c] = (j == 0);
    end
    chk(en_cnt == 0, "R9 feedback ignored before reference", en_cnt, 0);
  endtask

  initial begin
    int c, d, idx;
    bit e;
    void'($urandom(32'd5150));
    fr = '0; fp = '0; ps = '0; pol = 2'b11; mon = 1'b0; tsel = '0;
    clear_model(0); clear_model(1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cp_en === 2'b00, "R10 reset drive", cp_en, 0);
    chk(cp_up === 2'b00, "R10 reset level", cp_up, 0);
    chk(stat === 1'b0, "R10 reset status", stat, 0);

    fp_only(0);
    ps[1] = 1'b1;
    @(negedge clk);
    chk(stat === 1'b0, "R6 one loop unlocked", stat, 0);

    // R5 qualification
    run_pair(0, 1); run_pair(0, 2);
    chk(stat === 1'b0, "R5 not yet locked", stat, 0);
    run_pair(0, 0);
    chk(stat === 1'b1, "R5 locked after three", stat, 1);
    run_pair(0, 5);   // R4
    run_pair(0, 2); run_pair(0, 2); run_pair(0, 4);
    run_pair(0, 1); run_pair(0, 1);
    chk(stat === 1'b0, "R5 count restarted", stat, 0);
    run_pair(0, -1);
    chk(stat === 1'b1, "R5 relocked", stat, 1);

    pol[0] = 1'b0;
    run_pair(0, 3); run_pair(0, -3); run_pair(0, -2);
    pol[0] = 1'b1;
    run_pair(0, -4);
    run_pair(0, 1); run_pair(0, 1); run_pair(0, 1);

    // R8 power-save in the middle of a pulse
    @(negedge clk); fr[0] = 1'b1;
    @(negedge clk); fr[0] = 1'b0;
    @(negedge clk);
    chk(cp_en[0] === 1'b1, "R1 pulse open", cp_en[0], 1);
    ps[0] = 1'b1;
    #1 chk(cp_en[0] === 1'b0, "R8 float at once", cp_en[0], 0);
    chk(stat === 1'b1, "R6 both in power-save", stat, 1);
    repeat (3) @(negedge clk);
    chk(cp_en[0] === 1'b0, "R8 stays floating", cp_en[0], 0);
    ps[0] = 1'b0;
    clear_model(0);
    @(negedge clk);
    chk(stat === 1'b0, "R8 lock cleared", stat, 0);
    chk(cp_en[0] === 1'b0, "R8 pulse cleared", cp_en[0], 0);
    fp_only(0);
    run_pair(0, 2); run_pair(0, 1); run_pair(0, 2);

    // second loop leaves power-save
    @(negedge clk); ps[1] = 1'b0; clear_model(1);
    #1 chk(stat === 1'b0, "R6 second loop unlocked", stat, 0);
    fp_only(1);
    run_pair(1, 1); run_pair(1, 0); run_pair(1, 2);
    chk(stat === 1'b1, "R6 both locked", stat, 1);

    for (int i = 0; i < 60; i++) begin
      c = int'($urandom_range(1, 0));
      d = int'($urandom_range(12, 0)) - 6;
      if (!armed_m[c] && d < 0) d = -d;
      pol[c] = 1'($urandom_range(1, 0));
      run_pair(c, d);
    end

    // R7 monitor routing
    mon = 1'b1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fr   = 2'($urandom_range(3, 0));
      fp   = 2'($urandom_range(3, 0));
      tsel = 2'(i % 4);
      #1;
      idx = int'(tsel[0]);
      e = tsel[1] ? fp[idx] : fr[idx];
      chk(stat === e, "R7 monitor route", stat, e);
    end
    finish_run();
  end
endmodule